// File: doc/BRIEF.md
# Staged Reset Sequencer

The block turns three reset causes into a set of staged, active-low reset outputs. The causes are a power-on reset input, an active-low external reset pin and a watchdog time-out request. It runs entirely on a slow (32 kHz class) clock. Power-on reset asserts every output at once, with no clock edge needed. After power-on reset ends, the block keeps the outputs asserted for a fixed stretch of slow-clock cycles.

The external pin and the watchdog request each pass through a two-flop synchronizer. A counter then qualifies the external pin: a low pulse shorter than the qualification length is treated as a glitch and dropped. When every cause has gone away, the outputs are released in two steps. The memory-controller reset is freed first, and the system reset and the reset output pin follow a fixed number of cycles later. Any cause that arrives while this release is in progress starts it again from zero.

Only power-on reset clears the sequencer's own state. The external pin and the watchdog reset the rest of the chip but do not reset the sequencer. All cycle counts are parameters, so a bench can use short values in place of the full 9600-cycle power-on stretch.

Top module: `rstseq_top`

## Requirements
- R1: While `por` is 1, `mem_rst_n`, `sys_rst_n` and `rst_out_n` are all 0. This holds within the same clock period in which `por` rises, without any clock edge.
- R2: Count rising edges from the first edge after `por` falls. `mem_rst_n` goes to 1 after edge POR_CYCLES+MEM_DELAY, and `sys_rst_n` and `rst_out_n` go to 1 after edge POR_CYCLES+SYS_DELAY.
- R3: A low pulse on `ext_rst_n` that spans fewer than QUAL_CYCLES rising edges leaves all three outputs at 1.
- R4: A low level on `ext_rst_n` that lasts for at least QUAL_CYCLES edges drives all outputs to 0 after edge QUAL_CYCLES+3, counted from the first edge that sees the pin low.
- R5: After `ext_rst_n` returns to 1, `mem_rst_n` rises after edge 3+MEM_DELAY and `sys_rst_n` rises after edge 3+SYS_DELAY, counted from the first edge that sees the pin high.
- R6: A `wdog_req` level of 1 (one cycle is enough) drives all outputs to 0 after edge 3, counted from its first edge. After the request drops, `mem_rst_n` rises after edge 2+MEM_DELAY and `sys_rst_n` after edge 2+SYS_DELAY.
- R7: A cause that arrives while the outputs are being released resets the release count to zero. Both release points are then measured from the end of that new cause.
- R8: An external reset during the power-on stretch does not restart the stretch. The release points of R2 are unchanged as long as the external reset ends early enough.
- R9: `rst_out_n` equals `sys_rst_n` at every clock edge.
- R10: `sys_rst_n` is never 1 while `mem_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock that every count runs on |
| por | input | 1 | Power-on reset, active high, asserts the outputs asynchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to `clk_slow` |
| wdog_req | input | 1 | Watchdog time-out request, active high |
| mem_rst_n | output | 1 | Memory-controller reset, active low, released first |
| sys_rst_n | output | 1 | Internal system reset, active low, released last |
| rst_out_n | output | 1 | Reset output pin, active low, same timing as `sys_rst_n` |

## Verification
The case most likely to go wrong is a watchdog request that reaches the end of its synchronizer on the same edge at which the external-reset qualifier clears. If that happens, the release count must restart from the watchdog and not from the pin. The bench provokes this by dropping the pin and then raising a one-cycle watchdog request one cycle later. It judges the result by checking that each output rises exactly one cycle later than it would with the pin alone, which is the later of the two independently computed release points. A second scenario injects the watchdog well into the staged release and checks that `mem_rst_n`, already released, falls again and then rises at the new point.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Reset causes after synchronization and qualification.
    typedef struct packed {
        logic por;   // power-on stretch still running
        logic ext;   // qualified external pin reset
        logic wdog;  // synchronized watchdog request
    } rst_src_t;

    // Active-low staged reset outputs.
    typedef struct packed {
        logic mem_n;
        logic sys_n;
        logic out_n;
    } rst_out_t;

    // Number of bits needed to hold a count from 0 to n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic por,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge por) begin
                if (por) chain <= RESET_VAL;
                else     chain <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or posedge por) begin
                if (por) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_qual.sv
module rstseq_qual #(
    parameter int QUAL_CYCLES = 4
) (
    input  logic clk,
    input  logic por,
    input  logic low_s,
    output logic active
);
    localparam int W = rstseq_pkg::cnt_w(QUAL_CYCLES);
    localparam logic [W-1:0] LIMIT = W'(QUAL_CYCLES);

    logic [W-1:0] run_cnt;

    // Counts consecutive low samples and saturates at the limit.
    always_ff @(posedge clk or posedge por) begin
        if (por)             run_cnt <= '0;
        else if (!low_s)     run_cnt <= '0;
        else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
    end

    assign active = (run_cnt == LIMIT);
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
    parameter int CYCLES = 9600
) (
    input  logic clk,
    input  logic por,
    output logic active
);
    localparam int W = rstseq_pkg::cnt_w(CYCLES);
    localparam logic [W-1:0] LIMIT = W'(CYCLES);

    logic [W-1:0] hold_cnt;

    // Cleared only by power-on reset; other causes never touch it.
    always_ff @(posedge clk or posedge por) begin
        if (por)                    hold_cnt <= '0;
        else if (hold_cnt != LIMIT) hold_cnt <= hold_cnt + 1'b1;
    end

    assign active = (hold_cnt != LIMIT);
endmodule

// File: rtl/rstseq_stage.sv
module rstseq_stage
    import rstseq_pkg::*;
#(
    parameter int MEM_DELAY = 7,
    parameter int SYS_DELAY = 14
) (
    input  logic     clk,
    input  logic     por,
    input  logic     trigger,
    output rst_out_t outs
);
    localparam int W = cnt_w(SYS_DELAY);
    localparam logic [W-1:0] MEM_PT = W'(MEM_DELAY);
    localparam logic [W-1:0] SYS_PT = W'(SYS_DELAY);

    logic [W-1:0] rel_cnt;
    logic [W-1:0] rel_nx;

    always_comb begin
        if (trigger)               rel_nx = '0;
        else if (rel_cnt != SYS_PT) rel_nx = rel_cnt + 1'b1;
        else                       rel_nx = rel_cnt;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            rel_cnt <= '0;
            outs    <= '0;
        end else begin
            rel_cnt    <= rel_nx;
            outs.mem_n <= (rel_nx >= MEM_PT);
            outs.sys_n <= (rel_nx >= SYS_PT);
            outs.out_n <= (rel_nx >= SYS_PT);
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int POR_CYCLES  = 9600,
    parameter int QUAL_CYCLES = 4,
    parameter int MEM_DELAY   = 7,
    parameter int SYS_DELAY   = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_slow,
    input  logic por,
    input  logic ext_rst_n,
    input  logic wdog_req,
    output logic mem_rst_n,
    output logic sys_rst_n,
    output logic rst_out_n
);
    logic     ext_s;
    logic     wdog_s;
    logic     src_any;
    rst_src_t src;
    rst_out_t outs;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ext (
        .clk(clk_slow), .por(por), .d(ext_rst_n), .q(ext_s)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_wdog (
        .clk(clk_slow), .por(por), .d(wdog_req), .q(wdog_s)
    );

    rstseq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk_slow), .por(por), .low_s(~ext_s), .active(src.ext)
    );

    rstseq_stretch #(.CYCLES(POR_CYCLES)) u_stretch (
        .clk(clk_slow), .por(por), .active(src.por)
    );

    assign src.wdog = wdog_s;
    assign src_any  = |src;

    rstseq_stage #(.MEM_DELAY(MEM_DELAY), .SYS_DELAY(SYS_DELAY)) u_stage (
        .clk(clk_slow), .por(por), .trigger(src_any), .outs(outs)
    );

    assign mem_rst_n = outs.mem_n;
    assign sys_rst_n = outs.sys_n;
    assign rst_out_n = outs.out_n;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic clk,
    input logic por,
    input logic trigger,
    input logic mem_rst_n,
    input logic sys_rst_n,
    input logic rst_out_n
);
    assert_pin_tracks_sys_R9: assert property (@(posedge clk) disable iff (por)
        rst_out_n == sys_rst_n);

    assert_mem_not_after_sys_R10: assert property (@(posedge clk) disable iff (por)
        !mem_rst_n |-> !sys_rst_n);

    assert_cause_asserts_all_R7: assert property (@(posedge clk) disable iff (por)
        trigger |=> (!mem_rst_n && !sys_rst_n && !rst_out_n));

    assert_mem_freed_first_R2: assert property (@(posedge clk) disable iff (por)
        $rose(sys_rst_n) |-> $past(mem_rst_n));

    assert_release_sticks_R5: assert property (@(posedge clk) disable iff (por)
        (sys_rst_n && !trigger) |=> sys_rst_n);
endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk(clk_slow), .por(por), .trigger(src_any),
    .mem_rst_n(mem_rst_n), .sys_rst_n(sys_rst_n), .rst_out_n(rst_out_n)
);

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
    localparam int P = 40;
    localparam int Q = 4;
    localparam int M = 7;
    localparam int S = 14;
    localparam int NV = 6;
    // bit 8: 1 = watchdog cause, 0 = external pin; bits 7:0 = width in cycles
    localparam logic [8:0] VECS [NV] = '{9'h002, 9'h003, 9'h004, 9'h009, 9'h101, 9'h105};

    logic clk = 1'b0;
    logic por = 1'b0;
    logic ext_rst_n = 1'b1;
    logic wdog_req = 1'b0;
    logic mem_rst_n, sys_rst_n, rst_out_n;

    logic mh [0:100];
    logic sh [0:100];
    logic oh [0:100];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rstseq_top #(.POR_CYCLES(P), .QUAL_CYCLES(Q), .MEM_DELAY(M), .SYS_DELAY(S)) u_dut (
        .clk_slow(clk), .por(por), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
        .mem_rst_n(mem_rst_n), .sys_rst_n(sys_rst_n), .rst_out_n(rst_out_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives cause windows [from,to) in cycles and records outputs after each edge.
    task automatic run_scn(input int ef, input int et, input int wf, input int wt, input int ncyc);
        for (int i = 0; i <= ncyc; i++) begin
            if (i > 0) begin
                mh[i] = mem_rst_n;
                sh[i] = sys_rst_n;
                oh[i] = rst_out_n;
            end
            ext_rst_n = !(i >= ef && i < et);
            wdog_req  = (i >= wf && i < wt);
            @(negedge clk);
        end
    endtask

    function automatic int first_low(input int ncyc);
        for (int i = 1; i <= ncyc; i++) if (!sh[i]) return i;
        return -1;
    endfunction

    function automatic int rise_mem(input int from, input int ncyc);
        for (int i = from; i <= ncyc; i++) if (mh[i]) return i;
        return -1;
    endfunction

    function automatic int rise_sys(input int from, input int ncyc);
        for (int i = from; i <= ncyc; i++) if (sh[i]) return i;
        return -1;
    endfunction

    function automatic int rise_out(input int from, input int ncyc);
        for (int i = from; i <= ncyc; i++) if (oh[i]) return i;
        return -1;
    endfunction

    initial begin
        #200000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1 por = 1'b1;
        #2;
        // R1: reset state, no clock edge yet
        chk("R1 mem at reset", mem_rst_n, 0);
        chk("R1 sys at reset", sys_rst_n, 0);
        chk("R1 out at reset", rst_out_n, 0);
        repeat (3) @(negedge clk);
        chk("R1 sys held during por", sys_rst_n, 0);

        // R2: power-on stretch then staged release
        por = 1'b0;
        run_scn(0, 0, 0, 0, 60);
        chk("R2 mem still low", mh[P+M-1], 0);
        chk("R2 mem release", mh[P+M], 1);
        chk("R2 sys still low", sh[P+S-1], 0);
        chk("R2 sys release", sh[P+S], 1);
        chk("R9 out release", oh[P+S], 1);

        // Vector table: glitches, qualified pin resets, watchdog requests
        for (int v = 0; v < NV; v++) begin
            automatic bit is_wd = VECS[v][8];
            automatic int w = int'(VECS[v][7:0]);
            automatic int lo;
            chk("idle before vector", sys_rst_n, 1);
            if (is_wd) run_scn(0, 0, 0, w, 40);
            else       run_scn(0, w, 0, 0, 40);
            lo = first_low(40);
            if (!is_wd && w < Q) begin
                chk("R3 glitch ignored", lo, -1);
            end else if (!is_wd) begin
                chk("R4 pin assert point", lo, Q + 3);
                chk("R5 pin mem release", rise_mem(lo, 40), w + 3 + M);
                chk("R5 pin sys release", rise_sys(lo, 40), w + 3 + S);
                chk("R9 pin out release", rise_out(lo, 40), w + 3 + S);
            end else begin
                chk("R6 wdog assert point", lo, 3);
                chk("R6 wdog mem release", rise_mem(lo, 40), w + 2 + M);
                chk("R6 wdog sys release", rise_sys(lo, 40), w + 2 + S);
                chk("R9 wdog out release", rise_out(lo, 40), w + 2 + S);
            end
        end

        // R7: watchdog well into the release restarts it
        run_scn(0, 6, 15, 16, 45);
        chk("R7 mem freed before restart", mh[16], 1);
        chk("R7 mem reasserted", mh[20], 0);
        chk("R7 mem low before new point", mh[24], 0);
        chk("R7 mem new release", mh[25], 1);
        chk("R7 sys low before new point", sh[31], 0);
        chk("R7 sys new release", sh[32], 1);

        // R7: watchdog lands on the edge the qualifier clears
        run_scn(0, 6, 7, 8, 40);
        chk("R7 same-edge mem low", mh[16], 0);
        chk("R7 same-edge mem release", mh[17], 1);
        chk("R7 same-edge sys low", sh[23], 0);
        chk("R7 same-edge sys release", sh[24], 1);

        // R1: asynchronous assertion mid-period
        @(negedge clk);
        #2 por = 1'b1;
        #1;
        chk("R1 async mem", mem_rst_n, 0);
        chk("R1 async sys", sys_rst_n, 0);
        chk("R1 async out", rst_out_n, 0);

        // R8: pin reset inside the stretch leaves it unchanged
        @(negedge clk);
        por = 1'b0;
        run_scn(5, 9, 0, 0, 60);
        chk("R8 mem release", mh[P+M], 1);
        chk("R8 mem before", mh[P+M-1], 0);
        chk("R8 sys release", sh[P+S], 1);
        chk("R8 sys before", sh[P+S-1], 0);
        chk("R9 out release", oh[P+S], 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule